// File: doc/BRIEF.md
# Banked Data Address Translator

This block turns a file-register operand from an 8-bit banked microcontroller core into a 12-bit data memory address. It holds two writable registers: a 4-bit bank register and a 12-bit pointer. The pointer is loaded one byte at a time, as a high half and a low half. Every access takes one of four paths:

- **Bank path.** The bank register is placed in front of the 8-bit operand.
- **Direct path.** The fixed access bank is used. Its upper half lands on the special-function area at the top of memory.
- **Window path.** When the extended mode is on, the lower 96 locations of the access bank move into a window that starts at the pointer.
- **Indirect path.** An indirect access returns the pointer unchanged.

The core uses the effective address to reach the data array. It also gets a 2-bit code that names the path taken and a flag for a window that wrapped past the top of memory. The address logic is combinational. A parameter can add one register stage after it for pipelined cores.

Top module: `bank_addr_xlate`

## Requirements
- R1: After reset, the bank register and the pointer both hold zero.
- R2: When the access-select input is 1 and no indirect access is requested, the address is {bank register, operand} in both modes, and the path code is 00.
- R3: When access-select is 0 and the operand is in 60h–FFh, the address is F00h + operand in both modes, with path code 01 and overflow 0.
- R4: When access-select is 0, extended mode is off and the operand is 00h–5Fh, the address is the operand itself (top nibble 0), with path code 01.
- R5: When access-select is 0, extended mode is on and the operand is 00h–5Fh, the address is (pointer + operand) modulo 4096, with path code 10. For example, with the pointer at 120h, operand 00h gives 120h and operand 5Fh gives 17Fh.
- R6: The overflow output is 1 only on the window path, and only when pointer + operand exceeds FFFh.
- R7: An indirect request takes priority over all other inputs. It gives the pointer unchanged, path code 11 and overflow 0.
- R8: A low-half write loads pointer bits 7:0 from the 8-bit write data. A high-half write loads pointer bits 11:8 from write data bits 3:0. The half that is not written keeps its value.
- R9: A bank write loads the 4-bit bank register on the clock edge. It leaves the pointer unchanged.
- R10: With the output-register parameter set, the address, path code and overflow appear one clock later than in the combinational build, with the same values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bsrWrEn | input | 1 | Bank register write strobe |
| bsrWrData | input | 4 | Bank register write data |
| ptrHiWrEn | input | 1 | Pointer high-half write strobe |
| ptrLoWrEn | input | 1 | Pointer low-half write strobe |
| ptrWrData | input | 8 | Pointer write data byte |
| fileAddr | input | 8 | File-register operand |
| accessSel | input | 1 | 1 selects the bank path, 0 selects the access bank |
| extMode | input | 1 | Extended mode enable (window remap) |
| indirect | input | 1 | Indirect access request |
| effAddr | output | 12 | Effective data address |
| mapKind | output | 2 | Path code: 00 bank, 01 direct, 10 window, 11 indirect |
| winOvf | output | 1 | Window sum wrapped past FFFh |

## Verification
A wrong bank or pointer register bit shows up at the address outputs on the next bank-path or indirect access. The stored value is visible with no further delay. A write that hits the wrong pointer half, or a corrupted pointer, therefore shows up on the next indirect access. A steering error shows up in the same cycle, as a wrong path code or as an address that falls outside the window's 96-location span. In the pipelined build each of these arrives exactly one cycle later.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [1:0] {
    MAP_BANK     = 2'b00,
    MAP_DIRECT   = 2'b01,
    MAP_WINDOW   = 2'b10,
    MAP_INDIRECT = 2'b11
  } mapKind_e;

  // steering strobes from control to datapath; none set means low direct
  typedef struct packed {
    logic selIndirect;
    logic selBank;
    logic selWindow;
    logic selSfr;
  } steer_t;
endpackage

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
#(
  parameter int FILE_W   = 8,
  parameter int WIN_SPAN = 96
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FILE_W-1:0] fileAddr,
  input  logic              accessSel,
  input  logic              extMode,
  input  logic              indirect,
  output steer_t            steer,
  output mapKind_e          kind
);
  localparam logic [FILE_W-1:0] WIN_TOP = FILE_W'(WIN_SPAN);

  logic lowHalf;
  assign lowHalf = (fileAddr < WIN_TOP);

  always_comb begin
    steer = '0;
    kind  = MAP_DIRECT;
    if (indirect) begin
      steer.selIndirect = 1'b1;
      kind              = MAP_INDIRECT;
    end else if (accessSel) begin
      steer.selBank = 1'b1;
      kind          = MAP_BANK;
    end else if (!lowHalf) begin
      steer.selSfr = 1'b1;
    end else if (extMode) begin
      steer.selWindow = 1'b1;
      kind            = MAP_WINDOW;
    end
  end

  // at most one path steered at a time
  a_r7_steer_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(steer));
  // R7: indirect request overrides everything
  a_r7_indirect_wins: assert property (@(posedge clk) disable iff (!rstN)
    indirect |-> (kind == MAP_INDIRECT && !steer.selWindow));
  // R3: upper access half never enters the window
  a_r3_upper_not_window: assert property (@(posedge clk) disable iff (!rstN)
    (!indirect && !accessSel && !lowHalf) |-> !steer.selWindow);
endmodule

// File: rtl/xlate_dp.sv
module xlate_dp
  import xlate_pkg::*;
#(
  parameter int BANK_W   = 4,
  parameter int FILE_W   = 8,
  parameter int WIN_SPAN = 96,
  parameter bit REG_OUT  = 1'b0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     bsrWrEn,
  input  logic [BANK_W-1:0]        bsrWrData,
  input  logic                     ptrHiWrEn,
  input  logic                     ptrLoWrEn,
  input  logic [FILE_W-1:0]        ptrWrData,
  input  logic [FILE_W-1:0]        fileAddr,
  input  steer_t                   steer,
  input  mapKind_e                 kindIn,
  output logic [BANK_W+FILE_W-1:0] effAddr,
  output logic [1:0]               mapKind,
  output logic                     winOvf
);
  localparam int ADDR_W = BANK_W + FILE_W;
  localparam logic [ADDR_W-1:0] WIN_LAST = ADDR_W'(WIN_SPAN - 1);

  logic [BANK_W-1:0] bsrQ;
  logic [ADDR_W-1:0] ptrQ;
  logic [ADDR_W:0]   winSum;
  logic [ADDR_W-1:0] addrC;
  logic              ovfC;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bsrQ <= '0;
      ptrQ <= '0;
    end else begin
      if (bsrWrEn)   bsrQ <= bsrWrData;
      if (ptrLoWrEn) ptrQ[FILE_W-1:0] <= ptrWrData;
      if (ptrHiWrEn) ptrQ[ADDR_W-1:FILE_W] <= ptrWrData[BANK_W-1:0];
    end
  end

  assign winSum = {1'b0, ptrQ} + {{(BANK_W+1){1'b0}}, fileAddr};

  always_comb begin
    if (steer.selIndirect)    addrC = ptrQ;
    else if (steer.selBank)   addrC = {bsrQ, fileAddr};
    else if (steer.selWindow) addrC = winSum[ADDR_W-1:0];
    else if (steer.selSfr)    addrC = {{BANK_W{1'b1}}, fileAddr};
    else                      addrC = {{BANK_W{1'b0}}, fileAddr};
  end

  assign ovfC = steer.selWindow & winSum[ADDR_W];

  generate
    if (REG_OUT) begin : g_pipe
      always_ff @(posedge clk) begin
        if (!rstN) begin
          effAddr <= '0;
          mapKind <= '0;
          winOvf  <= 1'b0;
        end else begin
          effAddr <= addrC;
          mapKind <= kindIn;
          winOvf  <= ovfC;
        end
      end
    end else begin : g_comb
      assign effAddr = addrC;
      assign mapKind = kindIn;
      assign winOvf  = ovfC;
    end
  endgenerate

  // R5: window address stays within span above the pointer
  a_r5_window_span: assert property (@(posedge clk) disable iff (!rstN)
    steer.selWindow |-> ((addrC - ptrQ) <= WIN_LAST));
  // R6: no wrap means address at or above pointer; wrap means below it
  a_r6_no_wrap_above: assert property (@(posedge clk) disable iff (!rstN)
    (steer.selWindow && !ovfC) |-> (addrC >= ptrQ));
  a_r6_wrap_below: assert property (@(posedge clk) disable iff (!rstN)
    (steer.selWindow && ovfC) |-> (addrC < ptrQ));
  // R8: pointer only changes on a half write
  a_r8_ptr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ptrHiWrEn && !ptrLoWrEn) |=> $stable(ptrQ));
  // R9: bank write lands next cycle
  a_r9_bank_load: assert property (@(posedge clk) disable iff (!rstN)
    bsrWrEn |=> (bsrQ == $past(bsrWrData)));
endmodule

// File: rtl/bank_addr_xlate.sv
module bank_addr_xlate
  import xlate_pkg::*;
#(
  parameter int BANK_W   = 4,
  parameter int FILE_W   = 8,
  parameter int WIN_SPAN = 96,
  parameter bit REG_OUT  = 1'b0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     bsrWrEn,
  input  logic [BANK_W-1:0]        bsrWrData,
  input  logic                     ptrHiWrEn,
  input  logic                     ptrLoWrEn,
  input  logic [FILE_W-1:0]        ptrWrData,
  input  logic [FILE_W-1:0]        fileAddr,
  input  logic                     accessSel,
  input  logic                     extMode,
  input  logic                     indirect,
  output logic [BANK_W+FILE_W-1:0] effAddr,
  output logic [1:0]               mapKind,
  output logic                     winOvf
);
  steer_t   steer;
  mapKind_e kind;

  xlate_ctrl #(.FILE_W(FILE_W), .WIN_SPAN(WIN_SPAN)) i_ctrl (
    .clk(clk), .rstN(rstN), .fileAddr(fileAddr), .accessSel(accessSel),
    .extMode(extMode), .indirect(indirect), .steer(steer), .kind(kind)
  );

  xlate_dp #(.BANK_W(BANK_W), .FILE_W(FILE_W), .WIN_SPAN(WIN_SPAN),
             .REG_OUT(REG_OUT)) i_dp (
    .clk(clk), .rstN(rstN), .bsrWrEn(bsrWrEn), .bsrWrData(bsrWrData),
    .ptrHiWrEn(ptrHiWrEn), .ptrLoWrEn(ptrLoWrEn), .ptrWrData(ptrWrData),
    .fileAddr(fileAddr), .steer(steer), .kindIn(kind),
    .effAddr(effAddr), .mapKind(mapKind), .winOvf(winOvf)
  );
endmodule

// File: tb/test_bank_addr_xlate.sv
module test_bank_addr_xlate;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bsrWrEn = 1'b0;
  logic [3:0] bsrWrData = '0;
  logic       ptrHiWrEn = 1'b0;
  logic       ptrLoWrEn = 1'b0;
  logic [7:0] ptrWrData = '0;
  logic [7:0] fileAddr = '0;
  logic       accessSel = 1'b0;
  logic       extMode = 1'b0;
  logic       indirect = 1'b0;
  logic [11:0] effAddr, pAddr;
  logic [1:0]  mapKind, pKind;
  logic        winOvf, pOvf;
  int nChecks = 0;
  int nFails  = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bank_addr_xlate i_bank_addr_xlate (
    .clk(clk), .rstN(rstN), .bsrWrEn(bsrWrEn), .bsrWrData(bsrWrData),
    .ptrHiWrEn(ptrHiWrEn), .ptrLoWrEn(ptrLoWrEn), .ptrWrData(ptrWrData),
    .fileAddr(fileAddr), .accessSel(accessSel), .extMode(extMode),
    .indirect(indirect), .effAddr(effAddr), .mapKind(mapKind), .winOvf(winOvf)
  );

  bank_addr_xlate #(.REG_OUT(1'b1)) i_pipe (
    .clk(clk), .rstN(rstN), .bsrWrEn(bsrWrEn), .bsrWrData(bsrWrData),
    .ptrHiWrEn(ptrHiWrEn), .ptrLoWrEn(ptrLoWrEn), .ptrWrData(ptrWrData),
    .fileAddr(fileAddr), .accessSel(accessSel), .extMode(extMode),
    .indirect(indirect), .effAddr(pAddr), .mapKind(pKind), .winOvf(pOvf)
  );

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // called at a negedge: apply operand, check comb now, pipe one edge later
  task automatic probe(string tag, logic [7:0] f, logic acc, logic ext,
                       logic ind, int expA, int expK, int expO);
    fileAddr = f; accessSel = acc; extMode = ext; indirect = ind;
    #1;
    chk({tag, " addr"}, effAddr, expA);
    chk({tag, " kind"}, mapKind, expK);
    chk({tag, " ovf"},  winOvf,  expO);
    @(posedge clk); #1;
    chk({"R10 pipe ", tag}, {pOvf, pKind, pAddr}, (expO << 14) | (expK << 12) | expA);
    @(negedge clk);
  endtask

  task automatic wrBank(logic [3:0] v);
    bsrWrEn = 1'b1; bsrWrData = v;
    @(posedge clk); #1 bsrWrEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic wrPtr(logic hi, logic lo, logic [7:0] v);
    ptrHiWrEn = hi; ptrLoWrEn = lo; ptrWrData = v;
    @(posedge clk); #1 ptrHiWrEn = 1'b0; ptrLoWrEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    #1;
    chk("R1 pipe held in reset", {pOvf, pKind, pAddr}, 0);
    @(negedge clk); rstN = 1'b1;
    probe("R1 bank zero", 8'h00, 1'b1, 1'b0, 1'b0, 'h000, 0, 0);
    probe("R1 ptr zero", 8'h00, 1'b0, 1'b0, 1'b1, 'h000, 3, 0);
  endtask

  task automatic t_bank;
    wrBank(4'h5);
    probe("R9 R2 bank std", 8'h3C, 1'b1, 1'b0, 1'b0, 'h53C, 0, 0);
    probe("R2 bank ext", 8'h3C, 1'b1, 1'b1, 1'b0, 'h53C, 0, 0);
    probe("R2 bank low in ext", 8'h10, 1'b1, 1'b1, 1'b0, 'h510, 0, 0);
    wrBank(4'hF);
    probe("R2 bank top", 8'hFF, 1'b1, 1'b0, 1'b0, 'hFFF, 0, 0);
    probe("R9 ptr untouched", 8'h00, 1'b0, 1'b0, 1'b1, 'h000, 3, 0);
  endtask

  task automatic t_direct;
    probe("R4 low", 8'h10, 1'b0, 1'b0, 1'b0, 'h010, 1, 0);
    probe("R4 edge", 8'h5F, 1'b0, 1'b0, 1'b0, 'h05F, 1, 0);
    probe("R3 sfr base std", 8'h60, 1'b0, 1'b0, 1'b0, 'hF60, 1, 0);
    probe("R3 sfr top std", 8'hFF, 1'b0, 1'b0, 1'b0, 'hFFF, 1, 0);
  endtask

  task automatic t_window;
    wrPtr(1'b1, 1'b0, 8'h01);
    wrPtr(1'b0, 1'b1, 8'h20);
    probe("R5 win start", 8'h00, 1'b0, 1'b1, 1'b0, 'h120, 2, 0);
    probe("R5 win end", 8'h5F, 1'b0, 1'b1, 1'b0, 'h17F, 2, 0);
    probe("R3 sfr ext", 8'h60, 1'b0, 1'b1, 1'b0, 'hF60, 1, 0);
  endtask

  task automatic t_ptrBytes;
    wrPtr(1'b0, 1'b1, 8'h44);
    probe("R8 lo only", 8'h00, 1'b0, 1'b0, 1'b1, 'h144, 3, 0);
    wrPtr(1'b1, 1'b0, 8'hAB);
    probe("R8 hi nibble", 8'h00, 1'b0, 1'b0, 1'b1, 'hB44, 3, 0);
  endtask

  task automatic t_overflow;
    wrPtr(1'b1, 1'b1, 8'hFF);
    wrPtr(1'b0, 1'b1, 8'hF0);
    probe("R6 no wrap at top", 8'h0F, 1'b0, 1'b1, 1'b0, 'hFFF, 2, 0);
    probe("R6 wrap", 8'h20, 1'b0, 1'b1, 1'b0, 'h010, 2, 1);
    probe("R6 sfr no ovf", 8'h60, 1'b0, 1'b1, 1'b0, 'hF60, 1, 0);
    probe("R6 std mode no ovf", 8'h20, 1'b0, 1'b0, 1'b0, 'h020, 1, 0);
  endtask

  task automatic t_indirect;
    probe("R7 over bank", 8'h33, 1'b1, 1'b1, 1'b1, 'hFF0, 3, 0);
    probe("R7 over window", 8'h20, 1'b0, 1'b1, 1'b1, 'hFF0, 3, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_bank;
    t_direct;
    t_window;
    t_ptrBytes;
    t_overflow;
    t_indirect;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule